// File: doc/BRIEF.md
# Five-Stage Add Pipeline Without Operand Forwarding

This block is a small in-order pipeline with five stages: fetch, decode with register read, execute, memory and writeback. It runs only three-register add instructions, taken from an instruction memory that is filled through a load port. It works over a general-purpose register file that can be preloaded through a second port. The pipeline has neither forwarding nor stall logic, so a read-after-write dependency shows up as a stale operand.

Operands are read from the register file in decode, but the ALU first uses them one stage later. The sum then passes through the memory stage unchanged and reaches the register file in writeback. The register file lets a writeback land before a decode read in the same cycle. As a result, only the two instructions directly behind a producer see the old value of its destination register. Debug outputs expose the program counter, the decode/execute and execute/memory pipeline registers, and every register-file write.

Top module: `add_pipe5`

## Requirements
- R1: While reset is held, and right after it, the program counter reads 0, both debug valid flags are low and `wbEn` is low. Reset does not clear the instruction memory or the register file.
- R2: An instruction word is {opcode, rd, rs1, rs2} from MSB to LSB, with an opcode of `ADD_OPC` (default 1). Take the first rising edge after reset release as edge 0. A valid add at address a asserts `wbEn` after edge a+3, with `wbIdx`=rd and `wbData`=rs1+rs2.
- R3: An instruction with any other opcode is a bubble. It never asserts `wbEn` and changes no register.
- R4: The first and second instructions after an add that read its destination register get that register's value from before the add.
- R5: The third and every later instruction after an add that read its destination register get the new value. This holds because a writeback and a decode read of the same register in one cycle return the written data.
- R6: After edge j the program counter reads min(j+1, `progLen`). Addresses at or above `progLen` are fetched as bubbles, whatever the memory holds there.
- R7: A valid entry in the execute/memory register after edge j appears unchanged on `wbData`, with `wbEn` high, after edge j+1. When that entry is a bubble, `wbEn` stays low after edge j+1.
- R8: Register 0 is an ordinary register. It can be written, and it reads back what was written.
- R9: Sums wrap modulo 2^`DATA_W`.
- R10: When `preEn` is high, the register file takes `preData` into register `preIdx` on the clock edge. This works while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the PC and the pipeline registers |
| loadEn | input | 1 | Write strobe for the instruction memory |
| loadAddr | input | PC_W | Instruction memory address to write |
| loadInstr | input | INSTR_W | Instruction word to write |
| progLen | input | PC_W+1 | Number of instructions to execute from address 0 |
| preEn | input | 1 | Register preload strobe |
| preIdx | input | IDX_W | Register to preload |
| preData | input | DATA_W | Value to preload |
| dbgPc | output | PC_W+1 | Program counter |
| dbgIdExValid | output | 1 | Decode/execute register holds an add |
| dbgIdExOpA | output | DATA_W | First operand as read in decode |
| dbgIdExOpB | output | DATA_W | Second operand as read in decode |
| dbgExMemValid | output | 1 | Execute/memory register holds an add |
| dbgExMemSum | output | DATA_W | ALU result in the execute/memory register |
| wbEn | output | 1 | Register-file write strobe |
| wbIdx | output | IDX_W | Register written |
| wbData | output | DATA_W | Data written |

## Verification
A writeback and a decode read of the same register fall in the same cycle whenever a reader sits exactly three slots behind its producer. The bench provokes this case with handwritten sequences (through register 0 and through the example chain) and with a generated chain of dense dependencies. It also places readers one and two slots behind a producer, so that the stale window is exercised next to the same-cycle case. A behavioural model applies each writeback before each decode read in its per-cycle step. It predicts which value every reader gets, and each writeback and execute/memory entry is compared against it on every clock.

// File: rtl/add_pipe_pkg.sv
package add_pipe_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic fetchValid;   // fetch slot carries a real instruction
    logic decodeIsAdd;  // decode slot holds a valid add
  } pipe_ctrl_t;
endpackage

// File: rtl/pipe_regfile.sv
module pipe_regfile #(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic                   clk,
  input  logic                   wrEn,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   preEn,
  input  logic [IDX_W-1:0]       preIdx,
  input  logic [DATA_W-1:0]      preData,
  input  logic [1:0][IDX_W-1:0]  rdIdx,
  output logic [1:0][DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] regs [REG_CNT];

  always_ff @(posedge clk) begin
    if (preEn)
      regs[preIdx] <= preData;
    else if (wrEn)
      regs[wrIdx] <= wrData;
  end

  // write-then-read: a same-cycle write is seen by the reader
  for (genvar rp = 0; rp < 2; rp++) begin : g_rd
    always_comb begin
      if (wrEn && (wrIdx == rdIdx[rp]))
        rdData[rp] = wrData;
      else
        rdData[rp] = regs[rdIdx[rp]];
    end
  end
endmodule

// File: rtl/pipe_ctrl.sv
module pipe_ctrl
  import add_pipe_pkg::*;
#(
  parameter int IMEM_DEPTH          = 32,
  parameter int OPC_W               = 4,
  parameter logic [OPC_W-1:0] ADD_OPC = 1,
  localparam int PC_W               = $clog2(IMEM_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W:0]    progLen,
  input  logic             ifIdValid,
  input  logic [OPC_W-1:0] ifIdOpc,
  output logic [PC_W:0]    pc,
  output pipe_ctrl_t       ctrl
);
  localparam logic [PC_W:0] DEPTH_V = (PC_W+1)'(IMEM_DEPTH);

  logic inProgram;
  assign inProgram = (pc < progLen) && (pc < DEPTH_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc <= '0;
    else if (inProgram)
      pc <= pc + 1'b1;
  end

  always_comb begin
    ctrl.fetchValid  = inProgram;
    ctrl.decodeIsAdd = ifIdValid && (ifIdOpc == ADD_OPC);
  end
endmodule

// File: rtl/pipe_datapath.sv
module pipe_datapath
  import add_pipe_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int REG_CNT    = 8,
  parameter int IMEM_DEPTH = 32,
  parameter int OPC_W      = 4,
  localparam int PC_W      = $clog2(IMEM_DEPTH),
  localparam int IDX_W     = $clog2(REG_CNT),
  localparam int INSTR_W   = OPC_W + 3*IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pipe_ctrl_t         ctrl,
  input  logic [PC_W:0]      pc,
  input  logic               loadEn,
  input  logic [PC_W-1:0]    loadAddr,
  input  logic [INSTR_W-1:0] loadInstr,
  input  logic               preEn,
  input  logic [IDX_W-1:0]   preIdx,
  input  logic [DATA_W-1:0]  preData,
  output logic               ifIdValid,
  output logic [OPC_W-1:0]   ifIdOpc,
  output logic               idExValid,
  output logic [DATA_W-1:0]  idExOpA,
  output logic [DATA_W-1:0]  idExOpB,
  output logic               exMemValid,
  output logic [DATA_W-1:0]  exMemSum,
  output logic               wbEn,
  output logic [IDX_W-1:0]   wbIdx,
  output logic [DATA_W-1:0]  wbData
);
  logic [INSTR_W-1:0] imem [IMEM_DEPTH];

  always_ff @(posedge clk) begin
    if (loadEn)
      imem[loadAddr] <= loadInstr;
  end

  // fetch -> decode
  logic [INSTR_W-1:0] ifIdInstr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifIdValid <= 1'b0;
      ifIdInstr <= '0;
    end else begin
      ifIdValid <= ctrl.fetchValid;
      ifIdInstr <= ctrl.fetchValid ? imem[pc[PC_W-1:0]] : '0;
    end
  end

  logic [IDX_W-1:0] decRd;
  logic [1:0][IDX_W-1:0] decSrc;
  assign ifIdOpc   = ifIdInstr[INSTR_W-1 -: OPC_W];
  assign decRd     = ifIdInstr[3*IDX_W-1 -: IDX_W];
  assign decSrc[0] = ifIdInstr[2*IDX_W-1 -: IDX_W];
  assign decSrc[1] = ifIdInstr[IDX_W-1:0];

  logic [1:0][DATA_W-1:0] decOps;
  pipe_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_regs (
    .clk    (clk),
    .wrEn   (wbEn),
    .wrIdx  (wbIdx),
    .wrData (wbData),
    .preEn  (preEn),
    .preIdx (preIdx),
    .preData(preData),
    .rdIdx  (decSrc),
    .rdData (decOps)
  );

  // decode -> execute
  logic [IDX_W-1:0] idExRd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idExValid <= 1'b0;
      idExRd    <= '0;
      idExOpA   <= '0;
      idExOpB   <= '0;
    end else begin
      idExValid <= ctrl.decodeIsAdd;
      idExRd    <= decRd;
      idExOpA   <= decOps[0];
      idExOpB   <= decOps[1];
    end
  end

  // execute -> memory
  logic [DATA_W-1:0] aluSum;
  logic [IDX_W-1:0]  exMemRd;
  assign aluSum = idExOpA + idExOpB;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exMemValid <= 1'b0;
      exMemRd    <= '0;
      exMemSum   <= '0;
    end else begin
      exMemValid <= idExValid;
      exMemRd    <= idExRd;
      exMemSum   <= aluSum;
    end
  end

  // memory -> writeback (add passes through memory untouched)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbEn   <= 1'b0;
      wbIdx  <= '0;
      wbData <= '0;
    end else begin
      wbEn   <= exMemValid;
      wbIdx  <= exMemRd;
      wbData <= exMemSum;
    end
  end
endmodule

// File: rtl/add_pipe5.sv
module add_pipe5
  import add_pipe_pkg::*;
#(
  parameter int DATA_W                = 16,
  parameter int REG_CNT               = 8,
  parameter int IMEM_DEPTH            = 32,
  parameter int OPC_W                 = 4,
  parameter logic [OPC_W-1:0] ADD_OPC = 1,
  localparam int PC_W                 = $clog2(IMEM_DEPTH),
  localparam int IDX_W                = $clog2(REG_CNT),
  localparam int INSTR_W              = OPC_W + 3*IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loadEn,
  input  logic [PC_W-1:0]    loadAddr,
  input  logic [INSTR_W-1:0] loadInstr,
  input  logic [PC_W:0]      progLen,
  input  logic               preEn,
  input  logic [IDX_W-1:0]   preIdx,
  input  logic [DATA_W-1:0]  preData,
  output logic [PC_W:0]      dbgPc,
  output logic               dbgIdExValid,
  output logic [DATA_W-1:0]  dbgIdExOpA,
  output logic [DATA_W-1:0]  dbgIdExOpB,
  output logic               dbgExMemValid,
  output logic [DATA_W-1:0]  dbgExMemSum,
  output logic               wbEn,
  output logic [IDX_W-1:0]   wbIdx,
  output logic [DATA_W-1:0]  wbData
);
  pipe_ctrl_t       ctrlStrb;
  logic             ifIdValid;
  logic [OPC_W-1:0] ifIdOpc;

  pipe_ctrl #(.IMEM_DEPTH(IMEM_DEPTH), .OPC_W(OPC_W), .ADD_OPC(ADD_OPC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .progLen  (progLen),
    .ifIdValid(ifIdValid),
    .ifIdOpc  (ifIdOpc),
    .pc       (dbgPc),
    .ctrl     (ctrlStrb)
  );

  pipe_datapath #(.DATA_W(DATA_W), .REG_CNT(REG_CNT), .IMEM_DEPTH(IMEM_DEPTH),
                  .OPC_W(OPC_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrlStrb),
    .pc        (dbgPc),
    .loadEn    (loadEn),
    .loadAddr  (loadAddr),
    .loadInstr (loadInstr),
    .preEn     (preEn),
    .preIdx    (preIdx),
    .preData   (preData),
    .ifIdValid (ifIdValid),
    .ifIdOpc   (ifIdOpc),
    .idExValid (dbgIdExValid),
    .idExOpA   (dbgIdExOpA),
    .idExOpB   (dbgIdExOpB),
    .exMemValid(dbgExMemValid),
    .exMemSum  (dbgExMemSum),
    .wbEn      (wbEn),
    .wbIdx     (wbIdx),
    .wbData    (wbData)
  );
endmodule

// File: rtl/add_pipe5_chk.sv
module add_pipe5_chk #(
  parameter int DATA_W     = 16,
  parameter int IMEM_DEPTH = 32,
  localparam int PC_W      = $clog2(IMEM_DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W:0]     dbgPc,
  input logic              dbgIdExValid,
  input logic [DATA_W-1:0] dbgIdExOpA,
  input logic [DATA_W-1:0] dbgIdExOpB,
  input logic              dbgExMemValid,
  input logic [DATA_W-1:0] dbgExMemSum,
  input logic              wbEn,
  input logic [DATA_W-1:0] wbData
);
  // R2, R9: execute result is the wrapped sum of the decoded operands
  assert_exec_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dbgIdExValid |=> dbgExMemValid &&
      (dbgExMemSum == DATA_W'($past(dbgIdExOpA) + $past(dbgIdExOpB))));

  // R7: a valid memory-stage sum reaches writeback unchanged
  assert_mem_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dbgExMemValid |=> wbEn && (wbData == $past(dbgExMemSum)));

  // R3: a bubble in the memory stage never writes
  assert_bubble_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dbgExMemValid |=> !wbEn);

  // R6: the program counter never moves backwards while running
  assert_pc_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dbgPc >= $past(dbgPc)));

  // R6: the program counter steps by at most one
  assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dbgPc == $past(dbgPc)) || (dbgPc == $past(dbgPc) + 1'b1));
endmodule

bind add_pipe5 add_pipe5_chk #(.DATA_W(DATA_W), .IMEM_DEPTH(IMEM_DEPTH)) u_chk (.*);

// File: tb/add_pipe5_tb.sv
`timescale 1ns/1ps
module add_pipe5_tb;
  localparam int DW = 16;
  localparam int NREG = 8;
  localparam int DEPTH = 32;
  localparam int PCW = 5;
  localparam int IW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loadEn = 1'b0;
  logic [PCW-1:0] loadAddr = '0;
  logic [IW-1:0] loadInstr = '0;
  logic [PCW:0] progLen = '0;
  logic preEn = 1'b0;
  logic [2:0] preIdx = '0;
  logic [DW-1:0] preData = '0;
  logic [PCW:0] dbgPc;
  logic dbgIdExValid, dbgExMemValid, wbEn;
  logic [DW-1:0] dbgIdExOpA, dbgIdExOpB, dbgExMemSum, wbData;
  logic [2:0] wbIdx;

  always #2.5 clk = ~clk;

  add_pipe5 u_dut (.*);

  int checks = 0;
  int fails = 0;

  logic [IW-1:0] prog [DEPTH];
  int progN;
  logic [DW-1:0] initRegs [NREG];
  logic [DW-1:0] refRegs [NREG];
  logic [DW-1:0] res [DEPTH];
  int logIdx [64];
  logic [DW-1:0] logData [64];
  int logCnt;

  function automatic logic [IW-1:0] enc(int opc, int rd, int rs1, int rs2);
    return {4'(opc), 3'(rd), 3'(rs1), 3'(rs2)};
  endfunction

  function automatic bit isAdd(int a);
    return (a >= 0) && (a < progN) && (prog[a][12:9] == 4'd1);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic runScenario(string name);
    rst_n = 1'b0;
    @(negedge clk);
    for (int r = 0; r < NREG; r++) begin
      preEn = 1'b1; preIdx = 3'(r); preData = initRegs[r];
      @(negedge clk);
    end
    preEn = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      loadEn = 1'b1; loadAddr = PCW'(k); loadInstr = prog[k];
      @(negedge clk);
    end
    loadEn = 1'b0;
    progLen = (PCW+1)'(progN);
    @(posedge clk); #1;
    // R1: reset state
    chk("R1", {name, " pc"}, dbgPc, 0);
    chk("R1", {name, " idEx valid"}, dbgIdExValid, 0);
    chk("R1", {name, " exMem valid"}, dbgExMemValid, 0);
    chk("R1", {name, " wbEn"}, wbEn, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < NREG; r++) refRegs[r] = initRegs[r];
    logCnt = 0;
    for (int j = 0; j < progN + 8; j++) begin
      int b, e;
      @(posedge clk); #1;
      b = j - 3;
      e = j - 2;
      // writeback of b lands before decode of j in the same step (R5)
      if (isAdd(b)) refRegs[prog[b][8:6]] = res[b];
      if (isAdd(j)) res[j] = refRegs[prog[j][5:3]] + refRegs[prog[j][2:0]];
      chk("R6", {name, " pc"}, dbgPc, (j + 1 < progN) ? j + 1 : progN);
      chk("R7", {name, " exMem valid"}, dbgExMemValid, isAdd(e));
      if (isAdd(e)) chk("R7", {name, " exMem sum"}, dbgExMemSum, res[e]);
      chk("R3", {name, " wbEn"}, wbEn, isAdd(b));
      if (isAdd(b)) begin
        chk("R2", {name, " wbIdx"}, wbIdx, prog[b][8:6]);
        chk("R2", {name, " wbData"}, wbData, res[b]);
      end
      if (wbEn && logCnt < 64) begin
        logIdx[logCnt] = int'(wbIdx);
        logData[logCnt] = wbData;
        logCnt++;
      end
    end
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL R2 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // scenario 1: the stale-operand example
    for (int r = 0; r < NREG; r++) initRegs[r] = '0;
    initRegs[1] = 12; initRegs[2] = 192; initRegs[3] = 48;
    initRegs[4] = 1;  initRegs[5] = 2;
    for (int k = 0; k < DEPTH; k++) prog[k] = enc(1, 1, 1, 1);
    prog[0] = enc(1, 1, 2, 3);
    prog[1] = enc(1, 4, 1, 4);
    prog[2] = enc(1, 5, 1, 5);
    prog[3] = enc(1, 6, 1, 6);
    progN = 4;
    runScenario("example");
    chk("R6", "example write count", logCnt, 4);
    chk("R2", "producer r1", logData[0], 240);
    chk("R4", "first reader stale", logData[1], 13);
    chk("R4", "second reader stale", logData[2], 14);
    chk("R5", "third reader fresh", logData[3], 240);
    chk("R5", "third reader index", logIdx[3], 6);

    // scenario 2: bubbles, r0, wrap, preload, end of program
    for (int r = 0; r < NREG; r++) initRegs[r] = '0;
    initRegs[0] = 5; initRegs[1] = 16'hFFFF; initRegs[2] = 2;
    initRegs[3] = 7; initRegs[7] = 16'h1234;
    for (int k = 0; k < DEPTH; k++) prog[k] = enc(1, 1, 1, 1);
    prog[0] = enc(1, 0, 1, 2);
    prog[1] = enc(3, 3, 1, 1);
    prog[2] = enc(0, 3, 2, 2);
    prog[3] = enc(1, 4, 0, 0);
    prog[4] = enc(1, 5, 7, 0);
    prog[5] = enc(1, 6, 3, 3);
    progN = 6;
    runScenario("corner");
    chk("R3", "corner write count skips bubbles", logCnt, 4);
    chk("R9", "wrap into r0", logData[0], 1);
    chk("R8", "r0 written index", logIdx[0], 0);
    chk("R8", "r0 read back", logData[1], 2);
    chk("R10", "preloaded r7 used", logData[2], 16'h1235);
    chk("R3", "r3 untouched by bubbles", logData[3], 14);

    // scenario 3: dense generated dependency chain
    for (int r = 0; r < NREG; r++) initRegs[r] = DW'(r * 37 + 3);
    for (int k = 0; k < DEPTH; k++)
      prog[k] = enc((k % 7 == 3) ? 2 : 1, (k * 3 + 1) % 8, (k * 5) % 8, (k + 2) % 8);
    progN = 24;
    runScenario("chain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule